// File: doc/BRIEF.md
# Parallel Leaf Rule Matcher

This block checks one packet header against every rule held in a single wide leaf word of a classification tree. All checks happen in the same cycle. It reports whether any rule matched and, when several match, which one has priority. A header holds five fields: source address, destination address, source port, destination port and protocol. The word holds up to `NUM_RULES` packed 160-bit rules, and a count input says how many of them are live. Tree walking, memory reads and rule loading take place upstream.

Each rule holds three kinds of test:
- An inclusive range for each of the two ports.
- A prefix test on each address. The prefix length is packed into a 3-bit code. For prefixes of up to 27 bits, the low address bits that the prefix leaves unused carry the length.
- A protocol test. It compares the protocol value exactly, or ignores it when the rule's wildcard bit is set.

Lookups arrive on a valid/ready stream and results leave on a second stream. A lookup is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is registered and presented on the next edge. A result that the consumer does not take stays on the outputs unchanged. While that result is stalled, the input stream is closed to new lookups.

Top module: `wide_rule_matcher`

## Requirements
- R1: Rule k sits in bits [160k+159:160k] of `rule_word`. Within a rule, the fields are laid out as follows:
  - source address: [159:128]
  - source prefix code: [127:125]
  - destination address: [124:93]
  - destination prefix code: [92:90]
  - source port low bound: [89:74]
  - source port high bound: [73:58]
  - destination port low bound: [57:42]
  - destination port high bound: [41:26]
  - protocol value: [25:18]
  - protocol wildcard bit: [17]

  Bits [16:0] have no effect on matching.
- R2: Each port test passes only when low bound <= header port <= high bound, with both ends inclusive.
- R3: Prefix code 0 takes its prefix length from address bits [4:0]. It compares that many leading bits. A length of 0 matches any address. Stored lengths 28 to 31 under code 0 never match.
- R4: Prefix codes 1 to 5 give lengths 28 to 32 (length = 27 + code). Codes 6 and 7 never match.
- R5: When the protocol wildcard bit is 1, any protocol passes. When it is 0, the header protocol must equal the rule value.
- R6: Only rules whose index is below `valid_count` can match. A count of `NUM_RULES` or more enables every rule.
- R7: A rule matches only when all of its tests pass. When several rules match, the lowest index is reported. A lookup with no match reports `match_hit` = 0 and `match_idx` = 0.
- R8: A lookup accepted on a rising edge produces `out_valid` = 1 and its result right after the next rising edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `match_hit` and `match_idx` stay unchanged.
- R9: After reset, `out_valid`, `match_hit` and `match_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Lookup presented |
| in_ready | output | 1 | Lookup can be taken |
| hdr_src_ip | input | 32 | Header source address |
| hdr_dst_ip | input | 32 | Header destination address |
| hdr_src_port | input | 16 | Header source port |
| hdr_dst_port | input | 16 | Header destination port |
| hdr_proto | input | 8 | Header protocol |
| rule_word | input | 160*NUM_RULES | Packed leaf rules |
| valid_count | input | CNT_W | Number of live rules |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes result |
| match_hit | output | 1 | At least one live rule matched |
| match_idx | output | IDX_W | Index of the winning rule |

## Verification
The bench builds the matcher with `NUM_RULES` = 6. This keeps every word small enough to lay out by hand. It also gives a 3-bit count input, so the bench can apply the value 7, which exceeds the rule total, and check the path that enables every rule. Six slots are enough to place two matching rules at chosen positions and to move the count across each of them. The consumer's ready signal drops on a fixed pattern, so results meet both immediate drains and stalls.

// File: rtl/rmatch_pkg.sv
package rmatch_pkg;

  localparam int RULE_W = 160;

  // Field order from MSB down; a packed struct puts its first member on top.
  typedef struct packed {
    logic [31:0] src_addr;
    logic [2:0]  src_code;
    logic [31:0] dst_addr;
    logic [2:0]  dst_code;
    logic [15:0] sport_lo;
    logic [15:0] sport_hi;
    logic [15:0] dport_lo;
    logic [15:0] dport_hi;
    logic [7:0]  proto_val;
    logic        proto_any;
    logic [16:0] spare;
  } rule_t;

  typedef struct packed {
    logic [31:0] src_addr;
    logic [31:0] dst_addr;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [7:0]  proto;
  } hdr_t;

  // Code 0 carries the length in the unused address tail, up to this value.
  localparam logic [4:0] TAIL_LEN_MAX = 5'd27;
  localparam logic [5:0] CODE_BASE    = 6'd27;
  localparam logic [2:0] CODE_TOP     = 3'd5;

endpackage

// File: rtl/rm_ip_prefix.sv
module rm_ip_prefix
  import rmatch_pkg::*;
(
  input  logic [31:0] rule_addr,
  input  logic [2:0]  code,
  input  logic [31:0] pkt_addr,
  output logic        hit
);

  logic [5:0]  plen;
  logic        len_ok;
  logic [31:0] keep;

  always_comb begin
    plen   = '0;
    len_ok = 1'b0;
    if (code == 3'd0) begin
      plen   = {1'b0, rule_addr[4:0]};
      len_ok = (rule_addr[4:0] <= TAIL_LEN_MAX);
    end else if (code <= CODE_TOP) begin
      plen   = CODE_BASE + {3'b000, code};
      len_ok = 1'b1;
    end
  end

  always_comb begin
    if (plen == 6'd0) keep = '0;
    else              keep = 32'hFFFF_FFFF << (6'd32 - plen);
  end

  assign hit = len_ok && (((rule_addr ^ pkt_addr) & keep) == 32'h0);

endmodule

// File: rtl/rm_rule_check.sv
module rm_rule_check
  import rmatch_pkg::*;
(
  input  rule_t rule,
  input  hdr_t  hdr,
  output logic  hit
);

  logic src_ok, dst_ok, sport_ok, dport_ok, proto_ok;

  rm_ip_prefix src_u (
    .rule_addr (rule.src_addr),
    .code      (rule.src_code),
    .pkt_addr  (hdr.src_addr),
    .hit       (src_ok)
  );

  rm_ip_prefix dst_u (
    .rule_addr (rule.dst_addr),
    .code      (rule.dst_code),
    .pkt_addr  (hdr.dst_addr),
    .hit       (dst_ok)
  );

  assign sport_ok = (hdr.sport >= rule.sport_lo) && (hdr.sport <= rule.sport_hi);
  assign dport_ok = (hdr.dport >= rule.dport_lo) && (hdr.dport <= rule.dport_hi);
  assign proto_ok = rule.proto_any || (hdr.proto == rule.proto_val);

  assign hit = src_ok && dst_ok && sport_ok && dport_ok && proto_ok;

endmodule

// File: rtl/rm_priority_pick.sv
module rm_priority_pick #(
  parameter int N    = 48,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/wide_rule_matcher.sv
module wide_rule_matcher
  import rmatch_pkg::*;
#(
  parameter int NUM_RULES = 48,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int CNT_W    = $clog2(NUM_RULES + 1),
  localparam int WORD_W   = NUM_RULES * RULE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       hdr_src_ip,
  input  logic [31:0]       hdr_dst_ip,
  input  logic [15:0]       hdr_src_port,
  input  logic [15:0]       hdr_dst_port,
  input  logic [7:0]        hdr_proto,
  input  logic [WORD_W-1:0] rule_word,
  input  logic [CNT_W-1:0]  valid_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              match_hit,
  output logic [IDX_W-1:0]  match_idx
);

  hdr_t                 hdr;
  logic [NUM_RULES-1:0] raw_hit;
  logic [NUM_RULES-1:0] live;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;

  assign hdr = '{src_addr: hdr_src_ip, dst_addr: hdr_dst_ip,
                 sport: hdr_src_port, dport: hdr_dst_port, proto: hdr_proto};

  for (genvar k = 0; k < NUM_RULES; k++) begin : g_rule
    rm_rule_check chk_u (
      .rule (rule_t'(rule_word[k*RULE_W +: RULE_W])),
      .hdr  (hdr),
      .hit  (raw_hit[k])
    );
    assign live[k] = raw_hit[k] && (32'(valid_count) > k);
  end

  rm_priority_pick #(.N(NUM_RULES), .IW(IDX_W)) pick_u (
    .req (live),
    .any (any_hit),
    .idx (win_idx)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      match_hit <= 1'b0;
      match_idx <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      match_hit <= any_hit;
      match_idx <= any_hit ? win_idx : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/wide_rule_matcher_chk.sv
module wide_rule_matcher_chk #(
  parameter int NUM_RULES = 48,
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CNT_W-1:0] valid_count,
  input logic             out_valid,
  input logic             out_ready,
  input logic             match_hit,
  input logic [IDX_W-1:0] match_idx
);

  // R8
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(match_hit) && $stable(match_idx)));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R6
  idx_below_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!match_hit || (32'(match_idx) < 32'($past(valid_count)))));

  // R7
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !match_hit) |-> (match_idx == '0));

endmodule

bind wide_rule_matcher wide_rule_matcher_chk #(
  .NUM_RULES (NUM_RULES),
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .valid_count (valid_count),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .match_hit   (match_hit),
  .match_idx   (match_idx)
);

// File: tb/wide_rule_matcher_tb_top.sv
module wide_rule_matcher_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NR   = 6;
  localparam int IW   = 3;
  localparam int CW   = 3;
  localparam int WW   = NR * 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   hdr_src_ip = '0, hdr_dst_ip = '0;
  logic [15:0]   hdr_src_port = '0, hdr_dst_port = '0;
  logic [7:0]    hdr_proto = '0;
  logic [WW-1:0] rule_word = '0;
  logic [CW-1:0] valid_count = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          match_hit;
  logic [IW-1:0] match_idx;

  int errors = 0;
  int checks = 0;
  int sent = 0;
  int recvd = 0;
  bit ready_run = 1'b0;

  typedef struct {
    bit            hit;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_rule_matcher #(.NUM_RULES(NR)) dut_i (
    .clk, .rst_n, .in_valid, .in_ready,
    .hdr_src_ip, .hdr_dst_ip, .hdr_src_port, .hdr_dst_port, .hdr_proto,
    .rule_word, .valid_count,
    .out_valid, .out_ready, .match_hit, .match_idx
  );

  function automatic logic [159:0] mk(
    logic [31:0] sa, logic [2:0] sc, logic [31:0] da, logic [2:0] dc,
    logic [15:0] spl, logic [15:0] sph, logic [15:0] dpl, logic [15:0] dph,
    logic [7:0] pv, logic pm);
    return {sa, sc, da, dc, spl, sph, dpl, dph, pv, pm, 17'h0};
  endfunction

  function automatic logic [159:0] any_rule();
    return mk(32'h0, 3'd0, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
  endfunction

  function automatic logic [159:0] never_rule();
    return mk(32'h0, 3'd6, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
  endfunction

  function automatic logic [WW-1:0] never_word();
    logic [WW-1:0] w;
    for (int k = 0; k < NR; k++) w[k*160 +: 160] = never_rule();
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send(input logic [WW-1:0] w, input logic [CW-1:0] cnt,
                      input logic [31:0] sa, input logic [31:0] da,
                      input logic [15:0] sp, input logic [15:0] dp,
                      input logic [7:0] pr, input bit eh, input logic [IW-1:0] ei,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    rule_word = w; valid_count = cnt;
    hdr_src_ip = sa; hdr_dst_ip = da; hdr_src_port = sp; hdr_dst_port = dp;
    hdr_proto = pr; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    e.hit = eh; e.idx = eh ? ei : '0; e.tag = tag;
    exp_q.push_back(e);
    sent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // ready pattern
  initial begin
    int rc = 0;
    forever begin
      @(posedge clk); #1;
      if (ready_run) begin
        rc++;
        out_ready = (rc % 4 != 2);
      end
    end
  end

  // monitor / scoreboard
  bit            stalled = 1'b0;
  bit            st_hit;
  logic [IW-1:0] st_idx;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled && out_valid)
        check(match_hit == st_hit && match_idx == st_idx, "R8",
              $sformatf("stalled result changed: got %0b/%0d exp %0b/%0d",
                        match_hit, match_idx, st_hit, st_idx));
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        stalled = 1'b1; st_hit = match_hit; st_idx = match_idx;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "result with no lookup pending: got 1 exp 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          recvd++;
          check(match_hit == e.hit && match_idx == e.idx, e.tag,
                $sformatf("hit/idx got %0b/%0d exp %0b/%0d",
                          match_hit, match_idx, e.hit, e.idx));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [WW-1:0] w;
    logic [31:0] SA, DA;
    logic [15:0] SP, DP;
    logic [7:0]  PR;
    logic [159:0] r;
    SA = 32'h0A010203; DA = 32'hC0A80001; SP = 16'd1000; DP = 16'd80; PR = 8'd6;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !match_hit && match_idx == '0, "R9",
          $sformatf("reset outputs got %0b/%0b/%0d exp 0/0/0", out_valid, match_hit, match_idx));
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R8",
          $sformatf("idle after reset valid/ready got %0b/%0b exp 0/1", out_valid, in_ready));
    ready_run = 1'b1;

    // R1: single match at slot 2
    w = never_word(); w[2*160 +: 160] = any_rule();
    send(w, 3'd6, SA, DA, SP, DP, PR, 1, 3'd2, "R1");
    // R1: spare bits ignored
    r = any_rule(); r[16:0] = 17'h1FFFF;
    w = never_word(); w[3*160 +: 160] = r;
    send(w, 3'd6, SA, DA, SP, DP, PR, 1, 3'd3, "R1");

    // R7: priority and miss
    w = never_word(); w[1*160 +: 160] = any_rule(); w[4*160 +: 160] = any_rule();
    send(w, 3'd6, SA, DA, SP, DP, PR, 1, 3'd1, "R7");
    send(never_word(), 3'd6, SA, DA, SP, DP, PR, 0, 3'd0, "R7");

    // R6: count boundaries
    send(w, 3'd1, SA, DA, SP, DP, PR, 0, 3'd0, "R6");
    send(w, 3'd2, SA, DA, SP, DP, PR, 1, 3'd1, "R6");
    w = never_word(); w[4*160 +: 160] = any_rule();
    send(w, 3'd4, SA, DA, SP, DP, PR, 0, 3'd0, "R6");
    send(w, 3'd5, SA, DA, SP, DP, PR, 1, 3'd4, "R6");
    send(w, 3'd0, SA, DA, SP, DP, PR, 0, 3'd0, "R6");
    w = never_word(); w[5*160 +: 160] = any_rule();
    send(w, 3'd7, SA, DA, SP, DP, PR, 1, 3'd5, "R6");

    // R2: port bounds
    w = never_word();
    w[0] = 1'b0;
    w[0 +: 160] = mk(32'h0, 3'd0, 32'h0, 3'd0, 16'd1000, 16'd2000, 16'd80, 16'd80, 8'h0, 1'b1);
    send(w, 3'd6, SA, DA, 16'd1000, 16'd80, PR, 1, 3'd0, "R2");
    send(w, 3'd6, SA, DA, 16'd2000, 16'd80, PR, 1, 3'd0, "R2");
    send(w, 3'd6, SA, DA, 16'd2001, 16'd80, PR, 0, 3'd0, "R2");
    send(w, 3'd6, SA, DA, 16'd999,  16'd80, PR, 0, 3'd0, "R2");
    send(w, 3'd6, SA, DA, 16'd1500, 16'd81, PR, 0, 3'd0, "R2");

    // R3: code 0 length from tail bits
    w = never_word();
    w[3*160 +: 160] = mk(32'h0A010218, 3'd0, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, 32'h0A0102C8, DA, SP, DP, PR, 1, 3'd3, "R3");
    send(w, 3'd6, 32'h0A010305, DA, SP, DP, PR, 0, 3'd0, "R3");
    w = never_word();
    w[3*160 +: 160] = mk(32'h0A01021D, 3'd0, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, 32'h0A01021D, DA, SP, DP, PR, 0, 3'd0, "R3");
    w = never_word(); w[0 +: 160] = any_rule();
    send(w, 3'd6, 32'hFFFFFFFF, 32'h12345678, SP, DP, PR, 1, 3'd0, "R3");

    // R4: codes 1..7
    w = never_word();
    w[2*160 +: 160] = mk(32'h0, 3'd0, 32'hC0A80001, 3'd5, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, SA, 32'hC0A80001, SP, DP, PR, 1, 3'd2, "R4");
    send(w, 3'd6, SA, 32'hC0A80000, SP, DP, PR, 0, 3'd0, "R4");
    w = never_word();
    w[2*160 +: 160] = mk(32'h0, 3'd0, 32'hC0A80010, 3'd1, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, SA, 32'hC0A8001F, SP, DP, PR, 1, 3'd2, "R4");
    send(w, 3'd6, SA, 32'hC0A80000, SP, DP, PR, 0, 3'd0, "R4");
    w = never_word();
    w[2*160 +: 160] = mk(32'h0, 3'd0, 32'hC0A80001, 3'd6, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, SA, 32'hC0A80001, SP, DP, PR, 0, 3'd0, "R4");
    w[2*160 +: 160] = mk(32'h0, 3'd0, 32'hC0A80001, 3'd7, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'h0, 1'b1);
    send(w, 3'd6, SA, 32'hC0A80001, SP, DP, PR, 0, 3'd0, "R4");

    // R5: protocol
    w = never_word();
    w[1*160 +: 160] = mk(32'h0, 3'd0, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'd17, 1'b0);
    send(w, 3'd6, SA, DA, SP, DP, 8'd17, 1, 3'd1, "R5");
    send(w, 3'd6, SA, DA, SP, DP, 8'd6,  0, 3'd0, "R5");
    w[1*160 +: 160] = mk(32'h0, 3'd0, 32'h0, 3'd0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 8'd17, 1'b1);
    send(w, 3'd6, SA, DA, SP, DP, 8'd6,  1, 3'd1, "R5");

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(recvd == sent && exp_q.size() == 0, "R8",
          $sformatf("results got %0d exp %0d", recvd, sent));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule